// File: doc/BRIEF.md
# Interpolating Time-Interval Combiner

This block turns a pair of timing events into one binary interval word. A START event and a STOP event each arrive as a rising level on an input pin. Each input first passes through a multi-flop synchronizer, so the coarse counter's enable is never taken from a metastable flop. Each channel also supplies two fine codes, already in natural binary. The first is a 2-bit index of the quarter of the reference period (the segment of a four-phase clock) in which the edge fell. The second is a sub-segment code counting from 0 to `FINE_K-1` fine LSBs.

A coarse counter counts reference-clock edges from the detected START to the detected STOP. Both events see the same synchronizer latency, so the count equals the number of clock edges between the two input rises. The output is expressed in fine LSBs, with one reference period equal to `4*FINE_K` LSBs. It is the coarse count times the period, plus the START fine term, minus the STOP fine term. Each result, tagged with a saturation flag, is pushed into a small result FIFO. This lets back-to-back measurements proceed while the consumer is slow.

The result side is a valid/ready stream. A word is transferred on a clock edge where both `res_valid` and `res_ready` are high. While `res_valid` is high and `res_ready` is low, the head word is held unchanged. The block never stalls a measurement for back-pressure. A result that finds the FIFO full is discarded, and the `overrun` pin records this.

Top module: `interval_combiner`

## Requirements
- R1: After reset, `res_valid` and `overrun` are low.
- R2: A START or STOP event is the rising edge of its input level, seen after `SYNC_STAGES` flops. The segment and fine codes of a channel are sampled in the cycle its event is detected. The count N is the number of clock edges from the START input rise to the STOP input rise.
- R3: `res_word[SPAN_W-1:0]` equals N·4·FINE_K + (start_seg·FINE_K + start_fine) − (stop_seg·FINE_K + stop_fine). With FINE_K = 64, one count is 256 LSBs and one segment is 64 LSBs.
- R4: A STOP event while no measurement is open produces no result.
- R5: A START event while a measurement is open is ignored. The interval and the start codes come from the first START.
- R6: The count saturates at 2^CNT_W−1. `res_word[SPAN_W]` (the top bit) is set when the STOP event comes after the count has held at that ceiling for one edge (N > 2^CNT_W−1); when N equals 2^CNT_W−1 exactly, the bit is clear.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_word` does not change. Results leave in the order they were measured.
- R8: A result produced while the FIFO holds `FIFO_DEPTH` words is dropped. `overrun` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | START event level (asynchronous) |
| start_seg | input | 2 | START phase-segment index |
| start_fine | input | FW = log2(FINE_K) | START sub-segment code |
| stop_in | input | 1 | STOP event level (asynchronous) |
| stop_seg | input | 2 | STOP phase-segment index |
| stop_fine | input | FW | STOP sub-segment code |
| res_valid | output | 1 | Head result available |
| res_ready | input | 1 | Consumer accepts head result |
| res_word | output | SPAN_W+1 | {saturation flag, interval in fine LSBs} |
| overrun | output | 1 | Sticky: a result was dropped |

## Verification
Two situations are hard to reach from the ports. The first is the saturation boundary. The bench builds the block with a narrow counter and places STOP exactly 2^CNT_W−1 edges and then one edge more after START, which puts the flag on either side of the ceiling. The second is the drop path. The bench holds `res_ready` low across one more measurement than the FIFO holds, then drains the FIFO. This shows that the first words come out intact and in order, and that the extra word never appears.

// File: rtl/ti_pkg.sv
package ti_pkg;
  localparam int PHASES = 4;
  localparam int SEG_W  = 2;
  typedef enum logic {MS_IDLE, MS_OPEN} meas_state_e;
endpackage

// File: rtl/ti_sync_edge.sv
module ti_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], level_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ti_span_counter.sv
module ti_span_counter
  import ti_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FINE_K = 64,
  parameter int FW     = 6,
  parameter int SPAN_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic [SEG_W-1:0]  st_seg,
  input  logic [FW-1:0]     st_fine,
  input  logic              stop_hit,
  input  logic [SEG_W-1:0]  sp_seg,
  input  logic [FW-1:0]     sp_fine,
  output logic              push_o,
  output logic [SPAN_W:0]   word_o
);
  localparam logic [CNT_W-1:0]  CNT_CEIL = '1;
  localparam logic [SPAN_W-1:0] PERIOD   = SPAN_W'(PHASES * FINE_K);
  localparam logic [SPAN_W-1:0] SEG_LSB  = SPAN_W'(FINE_K);

  meas_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sat_q;
  logic [SPAN_W-1:0] st_term_q;
  logic [SPAN_W-1:0] st_term_now, sp_term_now, span_now;

  always_comb begin
    st_term_now = SPAN_W'(st_seg) * SEG_LSB + SPAN_W'(st_fine);
    sp_term_now = SPAN_W'(sp_seg) * SEG_LSB + SPAN_W'(sp_fine);
    span_now    = SPAN_W'(cnt_q) * PERIOD + st_term_q - sp_term_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MS_IDLE;
      cnt_q     <= '0;
      sat_q     <= 1'b0;
      st_term_q <= '0;
      push_o    <= 1'b0;
      word_o    <= '0;
    end else begin
      push_o <= 1'b0;
      unique case (state_q)
        MS_IDLE: if (start_hit) begin
          state_q   <= MS_OPEN;
          cnt_q     <= CNT_W'(1);
          sat_q     <= 1'b0;
          st_term_q <= st_term_now;
        end
        MS_OPEN: begin
          if (stop_hit) begin
            push_o  <= 1'b1;
            word_o  <= {sat_q, span_now};
            state_q <= MS_IDLE;
          end else if (cnt_q == CNT_CEIL) begin
            sat_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ti_result_fifo.sv
module ti_result_fifo #(
  parameter int DW    = 25,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] dout,
  output logic          drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, rd_q;
  logic          full, empty;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign valid_o = !empty;
  assign dout    = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      drop_o <= 1'b0;
    end else begin
      if (push && !full) wr_q <= wr_q + 1'b1;
      if (push && full)  drop_o <= 1'b1;
      if (!empty && ready_i) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/interval_combiner.sv
module interval_combiner
  import ti_pkg::*;
#(
  parameter  int CNT_W       = 16,
  parameter  int FINE_K      = 64,
  parameter  int FIFO_DEPTH  = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int FW          = $clog2(FINE_K),
  localparam int SPAN_W      = CNT_W + $clog2(PHASES * FINE_K)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic [1:0]        start_seg,
  input  logic [FW-1:0]     start_fine,
  input  logic              stop_in,
  input  logic [1:0]        stop_seg,
  input  logic [FW-1:0]     stop_fine,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [SPAN_W:0]   res_word,
  output logic              overrun
);
  logic start_hit, stop_hit, push;
  logic [SPAN_W:0] word;

  ti_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_start (
    .clk(clk), .rst_n(rst_n), .level_in(start_in), .rise_o(start_hit));
  ti_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .level_in(stop_in), .rise_o(stop_hit));

  ti_span_counter #(.CNT_W(CNT_W), .FINE_K(FINE_K), .FW(FW), .SPAN_W(SPAN_W)) u_span (
    .clk(clk), .rst_n(rst_n),
    .start_hit(start_hit), .st_seg(start_seg), .st_fine(start_fine),
    .stop_hit(stop_hit), .sp_seg(stop_seg), .sp_fine(stop_fine),
    .push_o(push), .word_o(word));

  ti_result_fifo #(.DW(SPAN_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(word),
    .valid_o(res_valid), .ready_i(res_ready), .dout(res_word), .drop_o(overrun));
endmodule

// File: rtl/ti_checker.sv
module ti_checker #(
  parameter int CNT_W  = 16,
  parameter int FINE_K = 64,
  parameter int SPAN_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            res_valid,
  input logic            res_ready,
  input logic [SPAN_W:0] res_word,
  input logic            overrun
);
  localparam longint PER   = 4 * FINE_K;
  localparam longint FLOOR = ((longint'(1) << CNT_W) - 1) * PER - (PER - 1);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_word));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R3
  span_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_word[SPAN_W-1:0] != '0);

  // R6
  sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_word[SPAN_W] |-> res_word[SPAN_W-1:0] >= SPAN_W'(FLOOR));
endmodule

bind interval_combiner ti_checker #(.CNT_W(CNT_W), .FINE_K(FINE_K), .SPAN_W(SPAN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_word(res_word), .overrun(overrun));

// File: tb/interval_combiner_tb_top.sv
module interval_combiner_tb_top;
  localparam int CW = 8;
  localparam int K  = 64;
  localparam int FW = 6;
  localparam int SW = CW + 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_in = 0, stop_in = 0, res_ready = 0;
  logic [1:0] start_seg = 0, stop_seg = 0;
  logic [FW-1:0] start_fine = 0, stop_fine = 0;
  logic res_valid, overrun;
  logic [SW:0] res_word;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  interval_combiner #(.CNT_W(CW), .FINE_K(K), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .start_seg(start_seg),
    .start_fine(start_fine), .stop_in(stop_in), .stop_seg(stop_seg),
    .stop_fine(stop_fine), .res_valid(res_valid), .res_ready(res_ready),
    .res_word(res_word), .overrun(overrun));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [SW:0] expect_word(int n, int ss, int sf, int ps, int pf, bit sat);
    int v;
    v = n * 4 * K + (ss * K + sf) - (ps * K + pf);
    return {sat, SW'(v)};
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_meas(int d, int ss, int sf, int ps, int pf);
    @(negedge clk);
    start_in = 1; start_seg = 2'(ss); start_fine = FW'(sf);
    repeat (d) @(negedge clk);
    stop_in = 1; stop_seg = 2'(ps); stop_fine = FW'(pf);
    repeat (4) @(negedge clk);
    start_in = 0; stop_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic get_result(string tag, logic [SW:0] exp);
    for (int i = 0; i < 60 && !res_valid; i++) @(negedge clk);
    check({tag, " valid"}, res_valid, 1);
    check(tag, res_word, exp);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 res_valid", res_valid, 0);
    check("R1 overrun", overrun, 0);
  endtask

  task automatic t_patterns;
    run_meas(10, 2, 17, 1, 40); get_result("R3 pattern a", expect_word(10, 2, 17, 1, 40, 0));
    run_meas(1, 0, 0, 3, 63);   get_result("R3 minimum", expect_word(1, 0, 0, 3, 63, 0));
    run_meas(3, 3, 63, 0, 0);   get_result("R2 short span", expect_word(3, 3, 63, 0, 0, 0));
    run_meas(37, 1, 5, 1, 5);   get_result("R3 equal fine", expect_word(37, 1, 5, 1, 5, 0));
  endtask

  task automatic t_stop_idle;
    @(negedge clk); stop_in = 1; stop_seg = 1; stop_fine = 9;
    repeat (4) @(negedge clk); stop_in = 0;
    repeat (10) @(negedge clk);
    check("R4 no result", res_valid, 0);
    run_meas(5, 1, 1, 2, 2); get_result("R4 after idle stop", expect_word(5, 1, 1, 2, 2, 0));
  endtask

  task automatic t_restart;
    @(negedge clk); start_in = 1; start_seg = 3; start_fine = 30;
    repeat (4) @(negedge clk); start_in = 0;
    repeat (4) @(negedge clk); start_in = 1; start_seg = 0; start_fine = 1;
    repeat (12) @(negedge clk); stop_in = 1; stop_seg = 2; stop_fine = 7;
    repeat (4) @(negedge clk); start_in = 0; stop_in = 0;
    repeat (4) @(negedge clk);
    get_result("R5 second start ignored", expect_word(20, 3, 30, 2, 7, 0));
  endtask

  task automatic t_saturate;
    run_meas(255, 1, 10, 0, 3); get_result("R6 at ceiling", expect_word(255, 1, 10, 0, 3, 0));
    run_meas(256, 1, 10, 0, 3); get_result("R6 past ceiling", expect_word(255, 1, 10, 0, 3, 1));
  endtask

  task automatic t_backpressure;
    logic [SW:0] held;
    for (int m = 0; m < DEPTH + 1; m++) run_meas(4 + m, m % 4, m, 0, 0);
    check("R8 overrun set", overrun, 1);
    held = res_word;
    repeat (3) @(negedge clk);
    check("R7 held word", res_word, held);
    for (int m = 0; m < DEPTH; m++)
      get_result("R7 order", expect_word(4 + m, m % 4, m, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R8 dropped word absent", res_valid, 0);
    check("R8 overrun sticky", overrun, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_patterns();
    t_stop_idle();
    t_restart();
    t_saturate();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule